// File: doc/BRIEF.md
# Dual-Channel Fan Speed Tachometer

This block measures the rotation speed of two fans from their tachometer pulse lines. Each channel counts reference ticks across one fan revolution, which is two tach pulses. Those ticks are first grouped by a programmable divider of 1, 2, 4 or 8. The result is an 8-bit count that saturates at 255. A larger count means a slower fan. Software turns the count into RPM as `RPM = K / (count * divider)`. For a 22.5 kHz reference, K is 1,350,000. The readings are quantized, and at a divider of 2 the slowest speed that can be told apart is near 2600 RPM.

Each finished measurement is published to a held count output. It is also compared against a per-channel 8-bit limit. When the count exceeds the limit, the fan is turning too slowly, and the channel raises a sticky alarm that holds until a one-cycle clear pulse acknowledges it. A fan with no pulses at all saturates the count, so it reads 255 and always alarms.

The reference tick is derived inside the block from the system clock, once every `REF_DIV` cycles. Every output is a plain held status signal, not a stream, so there is no handshake and no back-pressure. A new count simply replaces the old one when a window closes.

Top module: `fan_tach_monitor`

## Requirements
- R1: Each tach input passes through a two-flop synchronizer. Only rising edges of the synchronized signal are used, and the window runs from an opening rising edge to the second rising edge after it. That closing edge also opens the next window.
- R2: The published count is the number of complete groups of D reference ticks that fall strictly between the opening and closing edge detections. The tick prescaler restarts at every opening edge.
- R3: The divider code selects D as follows: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. With `REF_DIV` = 1 and tach pulses T clocks apart, the count is floor((2T-1)/D).
- R4: The count saturates at 255. If a 256th group completes before the window closes, 255 is published and the channel waits for a fresh opening edge. A stalled fan therefore reads 255.
- R5: A published count greater than the channel's limit sets that channel's alarm. A count equal to or below the limit does not set it.
- R6: A published count of 255 sets the alarm even when the limit is 255.
- R7: The alarm is sticky. It stays high after the fan recovers and falls only in the cycle after a clear pulse. If a set and a clear arrive in the same cycle, the set wins.
- R8: The two channels are independent. Each has its own divider, limit, count and alarm, and neither affects the other.
- R9: After reset, every count reads 0 and every alarm is low.
- R10: Between publications, the count output holds its last published value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_i | input | NUM_FANS | Raw tach pulse lines, one per fan |
| div_sel_i | input | 2*NUM_FANS | Divider code per channel; channel n uses bits [2n+1:2n] |
| limit_i | input | CNT_W*NUM_FANS | Slow-fan limit per channel; channel n uses bits [8n+7:8n] |
| alarm_clr_i | input | NUM_FANS | One-cycle acknowledge pulse that clears the sticky alarm |
| count_o | output | CNT_W*NUM_FANS | Last published count per channel |
| alarm_o | output | NUM_FANS | Sticky slow-fan alarm per channel |

## Verification
The bench pushes random pulse periods across all four divider codes. This exposes a window off by one tick, since such a design reads one count high or low, and a wrong divider decode, which reads double or half. Slow periods and a fully stopped fan drive the count into saturation. A design that wraps there would read a small value and miss the alarm, and one that compares only against the limit would stay quiet at a limit of 255. A fan that stalls and then recovers shows whether the alarm is sticky: an alarm that is not sticky would drop before the clear. Unequal settings on the two channels catch any sharing of state between them.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int DIV_SEL_W = 2;
  localparam int PRE_W     = 3;

  // Divider code 0..3 selects 1,2,4,8 reference ticks per counted group.
  function automatic logic [PRE_W-1:0] div_minus1(input logic [DIV_SEL_W-1:0] code);
    logic [PRE_W:0] d;
    d = (PRE_W+1)'(1) << code;
    return PRE_W'(d - 1'b1);
  endfunction
endpackage

// File: rtl/fan_ref_tick.sv
module fan_ref_tick #(
  parameter int REF_DIV = 5556
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (REF_DIV <= 1) begin : g_every_cycle
      assign tick_o = 1'b1;
    end else begin : g_counted
      localparam int RW = $clog2(REF_DIV);
      logic [RW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == RW'(REF_DIV - 1))  cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == RW'(REF_DIV - 1));

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/fan_tach_sync.sv
module fan_tach_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tach_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_tick_i,
  input  logic                 rise_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 pub_o,
  output logic [CNT_W-1:0]     pub_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {WAIT_OPEN = 2'd0, SEEN_OPEN = 2'd1, SEEN_MID = 2'd2} win_e;

  logic [CNT_W-1:0] acc_q, acc_n;
  logic [PRE_W-1:0] pre_q, pre_n;
  win_e             win_q, win_n;
  logic             group_done;

  assign group_done = ref_tick_i && (pre_q >= div_minus1(div_sel_i));

  always_comb begin
    acc_n     = acc_q;
    pre_n     = pre_q;
    win_n     = win_q;
    pub_o     = 1'b0;
    pub_cnt_o = acc_q;
    if (ref_tick_i) begin
      if (group_done) begin
        pre_n = '0;
        if (acc_q == CNT_MAX) begin
          pub_o     = 1'b1;
          pub_cnt_o = CNT_MAX;
          acc_n     = '0;
          win_n     = WAIT_OPEN;
        end else begin
          acc_n = acc_q + 1'b1;
        end
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
    if (rise_i) begin
      if (win_q == SEEN_OPEN) begin
        if (!pub_o) win_n = SEEN_MID;
      end else begin
        if (win_q == SEEN_MID) begin
          pub_o     = 1'b1;
          pub_cnt_o = acc_q;
        end
        acc_n = '0;
        pre_n = '0;
        win_n = SEEN_OPEN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pre_q <= '0;
      win_q <= WAIT_OPEN;
    end else begin
      acc_q <= acc_n;
      pre_q <= pre_n;
      win_q <= win_n;
    end
  end

  // R4
  pub_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pub_o |=> !pub_o);
  // R1
  open_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i && (win_q == WAIT_OPEN) |=> (acc_q == '0) && (win_q == SEEN_OPEN));
endmodule

// File: rtl/fan_alarm_latch.sv
module fan_alarm_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pub_i,
  input  logic [CNT_W-1:0] pub_cnt_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;
  logic             alarm_q;
  logic             slow_set;

  assign slow_set = pub_i && ((pub_cnt_i > limit_i) || (pub_cnt_i == CNT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (pub_i) count_q <= pub_cnt_i;
      if (slow_set)   alarm_q <= 1'b1;
      else if (clr_i) alarm_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign alarm_o = alarm_q;

  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q && !clr_i |=> alarm_q);
  // R7
  alarm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_q) |-> $past(clr_i));
  // R6
  sat_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pub_i && (pub_cnt_i == CNT_MAX) |=> alarm_q);
  // R5
  over_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pub_i && (pub_cnt_i > limit_i) |=> alarm_q && (count_q == $past(pub_cnt_i)));
  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pub_i |=> $stable(count_q));
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
  import fan_tach_pkg::*;
#(
  parameter int NUM_FANS = 2,
  parameter int CNT_W    = 8,
  parameter int REF_DIV  = 5556
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_FANS-1:0]           tach_i,
  input  logic [DIV_SEL_W*NUM_FANS-1:0] div_sel_i,
  input  logic [CNT_W*NUM_FANS-1:0]     limit_i,
  input  logic [NUM_FANS-1:0]           alarm_clr_i,
  output logic [CNT_W*NUM_FANS-1:0]     count_o,
  output logic [NUM_FANS-1:0]           alarm_o
);
  logic ref_tick;

  fan_ref_tick #(.REF_DIV(REF_DIV)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (ref_tick)
  );

  generate
    for (genvar ch = 0; ch < NUM_FANS; ch++) begin : g_fan
      logic             rise;
      logic             pub;
      logic [CNT_W-1:0] pub_cnt;

      fan_tach_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tach_i (tach_i[ch]),
        .rise_o (rise)
      );

      fan_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .rise_i     (rise),
        .div_sel_i  (div_sel_i[ch*DIV_SEL_W +: DIV_SEL_W]),
        .pub_o      (pub),
        .pub_cnt_o  (pub_cnt)
      );

      fan_alarm_latch #(.CNT_W(CNT_W)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pub_i     (pub),
        .pub_cnt_i (pub_cnt),
        .limit_i   (limit_i[ch*CNT_W +: CNT_W]),
        .clr_i     (alarm_clr_i[ch]),
        .count_o   (count_o[ch*CNT_W +: CNT_W]),
        .alarm_o   (alarm_o[ch])
      );
    end
  endgenerate
endmodule

// File: tb/tb_fan_tach_monitor.sv
module tb_fan_tach_monitor;
  localparam int NF = 2;
  localparam int CW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NF-1:0]   tach = '0;
  logic [2*NF-1:0] div_sel = '0;
  logic [CW*NF-1:0] limit = '1;
  logic [NF-1:0]   clr = '0;
  logic [CW*NF-1:0] count;
  logic [NF-1:0]   alarm;

  int n_tests = 0;
  int n_fail  = 0;
  int per [NF];
  int ph  [NF];
  bit done = 0;

  fan_tach_monitor #(.NUM_FANS(NF), .CNT_W(CW), .REF_DIV(1)) dut (
    .clk(clk), .rst_n(rst_n), .tach_i(tach), .div_sel_i(div_sel),
    .limit_i(limit), .alarm_clr_i(clr), .count_o(count), .alarm_o(alarm)
  );

  always #4 clk = ~clk;

  // Tach drivers: pulse every per[ch] clocks, 0 means stalled.
  always @(negedge clk) begin
    for (int ch = 0; ch < NF; ch++) begin
      if (per[ch] == 0) begin
        tach[ch] = 1'b0;
        ph[ch] = 0;
      end else begin
        ph[ch] = (ph[ch] + 1) % per[ch];
        tach[ch] = (ph[ch] < per[ch] / 2);
      end
    end
  end

  function automatic int exp_count(input int t, input int code);
    int g;
    if (t == 0) return 255;
    g = (2 * t - 1) / (1 << code);
    return (g > 255) ? 255 : g;
  endfunction

  function automatic bit exp_alarm(input int c, input int lim);
    return (c > lim) || (c == 255);
  endfunction

  function automatic int settle(input int t, input int code);
    int w;
    w = 6 * t + 20;
    if (exp_count(t, code) == 255) w = w + 2 * 257 * (1 << code) + 4 * t;
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [NF-1:0] m);
    @(negedge clk);
    clr = m;
    @(negedge clk);
    clr = '0;
  endtask

  task automatic run_case(input int t0, input int c0, input int l0,
                          input int t1, input int c1, input int l1, input string req);
    int w, w1, e0, e1;
    per[0] = t0; per[1] = t1;
    div_sel = {2'(c1), 2'(c0)};
    limit = {8'(l1), 8'(l0)};
    w = settle(t0, c0); w1 = settle(t1, c1);
    if (w1 > w) w = w1;
    wait_cyc(w);
    pulse_clr('1);
    wait_cyc(w);
    e0 = exp_count(t0, c0);
    e1 = exp_count(t1, c1);
    chk({req, " R2 R3 ch0 count"}, count[7:0], e0);
    chk({req, " R8 ch1 count"}, count[15:8], e1);
    chk({req, " R5 ch0 alarm"}, alarm[0], exp_alarm(e0, l0));
    chk({req, " R5 ch1 alarm"}, alarm[1], exp_alarm(e1, l1));
  endtask

  initial begin
    int seed, h0;
    seed = $urandom(20240517);
    per[0] = 0; per[1] = 0; ph[0] = 0; ph[1] = 0;
    wait_cyc(3);
    // R9 reset state
    chk("R9 count", count, 0);
    chk("R9 alarm", alarm, 0);
    rst_n = 1'b1;

    // R3 each divider code, directed
    run_case(100, 0, 255, 100, 1, 50, "R3 d1/d2");
    run_case(100, 2, 20, 100, 3, 30, "R3 d4/d8");
    // R5 exact limit boundary: count 99 vs limit 99 and 98
    run_case(50, 0, 99, 50, 0, 98, "R5 boundary");
    // R4 saturation exactly at 255 and beyond
    run_case(128, 0, 254, 200, 0, 200, "R4 saturate");
    // R6 stalled fan with limit 255
    run_case(0, 1, 255, 60, 0, 255, "R6 stall");

    // R7 sticky: ch0 alarmed from stall, fan recovers, limit 255
    per[0] = 30; limit[7:0] = 8'd255; div_sel[1:0] = 2'd0;
    wait_cyc(400);
    chk("R7 still set after recovery", alarm[0], 1);
    chk("R7 count recovered", count[7:0], 59);
    pulse_clr(2'b01);
    wait_cyc(200);
    chk("R7 cleared", alarm[0], 0);

    // R10 hold between publications
    h0 = count[7:0];
    per[0] = 0;
    wait_cyc(100);
    chk("R10 hold", count[7:0], h0);

    // Random mix
    for (int i = 0; i < 14; i++) begin
      int ta, tb_, ca, cb, la, lb;
      ta = 8 + ($urandom % 190);
      tb_ = 8 + ($urandom % 190);
      ca = $urandom % 4; cb = $urandom % 4;
      la = $urandom % 256; lb = $urandom % 256;
      run_case(ta, ca, la, tb_, cb, lb, "R1 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule